// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Selected Write Enable Mode

A first-in first-out buffer of 1024 nine-bit words whose write side and read side run on unrelated clocks. Each side keeps its own binary pointer, one bit wider than the address. The pointer is passed to the other clock domain in Gray code through a two-flop synchroniser. The write side computes a registered active-low full flag. The read side computes a registered active-low empty flag. A write while full does nothing, and a read while empty does nothing. Read data comes from an output register. That register keeps the last word actually read, and an active-low output enable can float the data pins.

One input pin has two jobs, and the job is fixed when the FIFO is reset. If the pin is high while reset is held, it acts as a second, active-high write enable, which allows depth expansion with several FIFOs. If the pin is low during reset, it becomes a load control. While the load control is low, FIFO reads and writes are held off, because those cycles belong to a separate offset-programming path that is not part of this block. The pin is sampled on every write-clock edge while reset is low, and on the first write-clock edge after reset is released.

Top module: `dcfifo_top`

## Requirements
- R1: While rst_ni is low, and afterwards until a word is written, empty_no is 0 and full_no is 1. The output register reads as 0 while oe_ni is 0.
- R2: The mode is taken from wen2_ld_i during reset (1 = dual enable, 0 = load) and does not change until the next reset, whatever the pin does afterwards.
- R3: A word is stored on a wr_clk_i rising edge only when wen1_ni is 0, wen2_ld_i is 1 and full_no is 1. Any other combination leaves the FIFO contents unchanged.
- R4: In load mode, a rising edge of rd_clk_i while wen2_ld_i is 0 does not remove a word. In dual-enable mode, wen2_ld_i has no effect on reads.
- R5: When ren1_ni and ren2_ni are both 0 and empty_no is 1, the next word in write order is loaded into the output register on that rd_clk_i rising edge. If only one of the two enables is 0, nothing is read.
- R6: full_no goes to 0 on the edge that stores the 1024th held word. Further writes are ignored until space is freed.
- R7: A read attempted while empty_no is 0 leaves the output register holding the last word read. empty_no is 0 exactly when no word is held, once the pointer synchronisers have settled.
- R8: Words come out in write order across pointer wrap-around.
- R9: When oe_ni is 1, rdata_o is high-impedance. When oe_ni is 0, rdata_o drives the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write clock |
| rd_clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen1_ni | input | 1 | Write enable, active low |
| wen2_ld_i | input | 1 | Second write enable (active high) or load control, chosen at reset |
| wdata_i | input | 9 | Write data |
| ren1_ni | input | 1 | Read enable 1, active low |
| ren2_ni | input | 1 | Read enable 2, active low |
| oe_ni | input | 1 | Output enable, active low |
| rdata_o | output | 9 | Read data, high-impedance when disabled |
| empty_no | output | 1 | Empty flag, active low |
| full_no | output | 1 | Full flag, active low |

## Verification
The assertions assume that the write clock runs during reset, so that the mode is captured, and that wen2_ld_i is held steady for the whole reset pulse and for two write-clock edges after release. The assertions also assume that no read or write is requested while reset is low. The bench holds the dual-purpose pin before it lowers reset and keeps it there until well after release, and it leaves all enables idle throughout reset. The bench changes wen2_ld_i only while the read side is idle or on read-only test steps, so the read domain, which uses the pin without a synchroniser, always sees a stable level.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_DUAL = 1'b1
  } wen2_mode_e;
endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
module fifo_sync #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/fifo_mem.sv
`timescale 1ns/1ps
module fifo_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10
) (
  input  logic              wr_clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // output register only moves on an accepted read
  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W:0]   rgray_sync_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W:0]   wbin_o,
  output logic [ADDR_W:0]   wgray_o,
  output logic              full_no
);
  logic [ADDR_W:0] bin_nxt, gray_nxt;
  logic            full_nxt;

  assign we_o     = wr_req_i & full_no;
  assign bin_nxt  = wbin_o + {{ADDR_W{1'b0}}, we_o};
  assign gray_nxt = (bin_nxt >> 1) ^ bin_nxt;
  // full: top two Gray bits inverted, rest equal
  assign full_nxt = gray_nxt == {~rgray_sync_i[ADDR_W:ADDR_W-1], rgray_sync_i[ADDR_W-2:0]};
  assign waddr_o  = wbin_o[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_o  <= '0;
      wgray_o <= '0;
      full_no <= 1'b1;
    end else begin
      wbin_o  <= bin_nxt;
      wgray_o <= gray_nxt;
      full_no <= ~full_nxt;
    end
  end
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [ADDR_W:0]   wgray_sync_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rbin_o,
  output logic [ADDR_W:0]   rgray_o,
  output logic              empty_no
);
  logic [ADDR_W:0] bin_nxt, gray_nxt;

  assign re_o     = rd_req_i & empty_no;
  assign bin_nxt  = rbin_o + {{ADDR_W{1'b0}}, re_o};
  assign gray_nxt = (bin_nxt >> 1) ^ bin_nxt;
  assign raddr_o  = rbin_o[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_o   <= '0;
      rgray_o  <= '0;
      empty_no <= 1'b0;
    end else begin
      rbin_o   <= bin_nxt;
      rgray_o  <= gray_nxt;
      empty_no <= ~(gray_nxt == wgray_sync_i);
    end
  end
endmodule

// File: rtl/dcfifo_top.sv
`timescale 1ns/1ps
module dcfifo_top #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wen1_ni,
  input  logic              wen2_ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_no,
  output logic              full_no
);
  import fifo_pkg::*;

  localparam int PTR_W = ADDR_W + 1;

  logic              in_rst_q;
  wen2_mode_e        mode_q;
  logic              mode_dual;
  logic              wr_req, rd_req, we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wbin, wgray, rbin, rgray;
  logic [PTR_W-1:0]  wgray_rs, rgray_ws;
  logic [DATA_W-1:0] rdata_q;

  // reset seen in the write domain; mode pin captured while it is set
  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) in_rst_q <= 1'b1;
    else         in_rst_q <= 1'b0;
  end

  always_ff @(posedge wr_clk_i) begin
    if (in_rst_q) mode_q <= wen2_mode_e'(wen2_ld_i);
  end

  // quasi-static after reset, used in both domains
  assign mode_dual = (mode_q == MODE_DUAL);

  assign wr_req = ~wen1_ni & wen2_ld_i;
  assign rd_req = ~ren1_ni & ~ren2_ni & (mode_dual | wen2_ld_i);

  fifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i        (wr_clk_i),
    .rst_ni       (rst_ni),
    .wr_req_i     (wr_req),
    .rgray_sync_i (rgray_ws),
    .we_o         (we),
    .waddr_o      (waddr),
    .wbin_o       (wbin),
    .wgray_o      (wgray),
    .full_no      (full_no)
  );

  fifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i        (rd_clk_i),
    .rst_ni       (rst_ni),
    .rd_req_i     (rd_req),
    .wgray_sync_i (wgray_rs),
    .re_o         (re),
    .raddr_o      (raddr),
    .rbin_o       (rbin),
    .rgray_o      (rgray),
    .empty_no     (empty_no)
  );

  fifo_sync #(.W(PTR_W)) u_sync_w2r (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_rs)
  );

  fifo_sync #(.W(PTR_W)) u_sync_r2w (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_ws)
  );

  fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk_i (wr_clk_i),
    .we_i     (we),
    .waddr_i  (waddr),
    .wdata_i  (wdata_i),
    .rd_clk_i (rd_clk_i),
    .rst_ni   (rst_ni),
    .re_i     (re),
    .raddr_i  (raddr),
    .rdata_o  (rdata_q)
  );

  assign rdata_o = oe_ni ? {DATA_W{1'bz}} : rdata_q;
endmodule

// File: rtl/dcfifo_chk.sv
`timescale 1ns/1ps
module dcfifo_chk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              wen1_ni,
  input logic              wen2_ld_i,
  input logic              ren1_ni,
  input logic              ren2_ni,
  input logic              mode_dual,
  input logic              full_no,
  input logic              empty_no,
  input logic [ADDR_W:0]   wbin,
  input logic [ADDR_W:0]   rbin,
  input logic [DATA_W-1:0] rdata_q
);
  localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

  always @(posedge rd_clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (!empty_no && rdata_q == '0)
        else $error("reset state wrong");
    end
  end

  assert_mode_hold_R2: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rst_ni, 2)) |-> $stable(mode_dual));

  assert_no_write_R3: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wen1_ni || !wen2_ld_i) |=> $stable(wbin));

  assert_load_blocks_read_R4: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (!mode_dual && !wen2_ld_i) |=> $stable(rbin));

  assert_read_advance_R5: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (empty_no && !ren1_ni && !ren2_ni && (mode_dual || wen2_ld_i)) |=> (rbin == $past(rbin) + ONE));

  assert_no_overflow_R6: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wbin));

  assert_no_underflow_R7: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !empty_no |=> ($stable(rbin) && $stable(rdata_q)));
endmodule

bind dcfifo_top dcfifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk_i  (wr_clk_i),
  .rd_clk_i  (rd_clk_i),
  .rst_ni    (rst_ni),
  .wen1_ni   (wen1_ni),
  .wen2_ld_i (wen2_ld_i),
  .ren1_ni   (ren1_ni),
  .ren2_ni   (ren2_ni),
  .mode_dual (mode_dual),
  .full_no   (full_no),
  .empty_no  (empty_no),
  .wbin      (wbin),
  .rbin      (rbin),
  .rdata_q   (rdata_q)
);

// File: tb/tb_dcfifo_top.sv
`timescale 1ns/1ps
module tb_dcfifo_top;
  localparam int DW    = 9;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk, rd_clk, rst_n;
  logic          wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
  logic [DW-1:0] wdata;
  wire  [DW-1:0] rdata;
  wire           empty_n, full_n;

  int            checks = 0;
  int            fails  = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_rd;
  bit            mode_dual_m;

  dcfifo_top #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .wr_clk_i (wr_clk), .rd_clk_i (rd_clk), .rst_ni (rst_n),
    .wen1_ni (wen1_n), .wen2_ld_i (wen2_ld), .wdata_i (wdata),
    .ren1_ni (ren1_n), .ren2_ni (ren2_n), .oe_ni (oe_n),
    .rdata_o (rdata), .empty_no (empty_n), .full_no (full_n)
  );

  initial begin
    wr_clk = 1'b0;
    forever #2 wr_clk = ~wr_clk;
  end

  initial begin
    rd_clk = 1'b0;
    #1;
    forever #2 rd_clk = ~rd_clk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic do_reset(input bit dual);
    @(negedge wr_clk);
    wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1; wen2_ld = dual;
    rst_n = 1'b0;
    repeat (4) @(negedge wr_clk);
    chk(empty_n == 1'b0, "R1 empty in reset", 32'(empty_n), 0);
    chk(full_n == 1'b1,  "R1 full in reset",  32'(full_n), 1);
    chk(rdata === '0,    "R1 data in reset",  32'(rdata), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge wr_clk);
    wen2_ld = 1'b1;
    mode_dual_m = dual;
    exp_q.delete();
    last_rd = '0;
    settle();
  endtask

  // driver: one write cycle, model decides acceptance
  task automatic wr_word(input logic [DW-1:0] d, input bit en2);
    bit acc;
    @(negedge wr_clk);
    chk(full_n == (exp_q.size() < DEPTH), "R6 full flag", 32'(full_n), 32'(exp_q.size() < DEPTH));
    acc = en2 && (exp_q.size() < DEPTH);
    wdata = d; wen1_n = 1'b0; wen2_ld = en2;
    @(posedge wr_clk);
    if (acc) exp_q.push_back(d);
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wen1_n = 1'b1; wen2_ld = 1'b1;
  endtask

  // monitor: one read cycle, pops and compares
  task automatic rd_word(input bit r1, input bit r2, input bit ld, input string req);
    bit pop;
    logic [DW-1:0] e;
    @(negedge rd_clk);
    chk(empty_n == (exp_q.size() > 0), "R7 empty flag", 32'(empty_n), 32'(exp_q.size() > 0));
    pop = !r1 && !r2 && (mode_dual_m || ld) && exp_q.size() > 0;
    ren1_n = r1; ren2_n = r2; wen2_ld = ld;
    @(posedge rd_clk);
    #1;
    if (pop) begin
      e = exp_q.pop_front();
      last_rd = e;
    end else e = last_rd;
    chk(rdata === e, req, 32'(rdata), 32'(e));
  endtask

  task automatic rd_idle();
    @(negedge rd_clk);
    ren1_n = 1'b1; ren2_n = 1'b1; wen2_ld = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; wen1_n = 1'b1; wen2_ld = 1'b1; wdata = '0;
    ren1_n = 1'b1; ren2_n = 1'b1; oe_n = 1'b0;
    mode_dual_m = 1'b1; last_rd = '0;

    // dual-enable mode
    do_reset(1'b1);
    chk(empty_n == 1'b0 && full_n == 1'b1, "R1 after release", {30'd0, empty_n, full_n}, 32'h1);

    wr_word(9'h1A5, 1'b0); // second enable low: no store
    wr_idle(); settle();
    chk(empty_n == 1'b0, "R3 gated write", 32'(empty_n), 0);

    wr_word(9'h0F0, 1'b1);
    wr_word(9'h10F, 1'b1);
    wr_word(9'h055, 1'b1);
    wr_idle(); settle();
    rd_word(1'b0, 1'b1, 1'b1, "R5 only ren1");
    rd_word(1'b1, 1'b0, 1'b1, "R5 only ren2");
    rd_word(1'b0, 1'b0, 1'b0, "R4 dual ignores pin");
    rd_word(1'b0, 1'b0, 1'b1, "R5 read");
    rd_word(1'b0, 1'b0, 1'b1, "R5 read last");
    rd_word(1'b0, 1'b0, 1'b1, "R7 hold on empty");
    rd_word(1'b0, 1'b0, 1'b1, "R7 hold again");
    rd_idle();

    oe_n = 1'b1; #1;
    chk(rdata === {DW{1'bz}}, "R9 float", 32'(rdata), 32'h1ff);
    oe_n = 1'b0; #1;
    chk(rdata === last_rd, "R9 drive", 32'(rdata), 32'(last_rd));

    // fill past capacity
    for (int i = 0; i < DEPTH + 6; i++) wr_word(DW'(i * 37 + 3), 1'b1);
    wr_idle();
    @(negedge wr_clk);
    chk(full_n == 1'b0, "R6 full reached", 32'(full_n), 0);
    settle();
    for (int i = 0; i < DEPTH + 1; i++) rd_word(1'b0, 1'b0, 1'b1, "R8 order full");
    rd_idle();
    chk(exp_q.size() == 0, "R6 extra writes dropped", 32'(exp_q.size()), 0);

    // wrap-around
    settle();
    for (int i = 0; i < 40; i++) wr_word(DW'(i * 11 + 100), 1'b1);
    wr_idle(); settle();
    for (int i = 0; i < 40; i++) rd_word(1'b0, 1'b0, 1'b1, "R8 order wrap");
    rd_idle();

    // reset with data held, into load mode
    settle();
    for (int i = 0; i < 5; i++) wr_word(DW'(i + 1), 1'b1);
    wr_idle(); settle();
    do_reset(1'b0);
    chk(rdata === '0 && empty_n == 1'b0, "R1 reset clears", 32'(rdata), 0);

    wr_word(9'h0AA, 1'b0); // load low: not a FIFO write
    wr_word(9'h111, 1'b1);
    wr_word(9'h122, 1'b1);
    wr_idle(); settle();
    rd_word(1'b0, 1'b0, 1'b0, "R4 load low blocks read");
    rd_word(1'b0, 1'b0, 1'b1, "R4 load high reads");
    rd_word(1'b0, 1'b0, 1'b0, "R2 mode kept after pin high");
    rd_word(1'b0, 1'b0, 1'b1, "R3 second word");
    rd_word(1'b0, 1'b0, 1'b1, "R7 hold load mode");
    rd_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule